// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the configuration of a small set of hardware breakpoint triggers and makes it reachable through one shared register window. Software or a debugger first writes an index into a select register. The data register and the info register then show the trigger at that index. The data register carries the trigger kind, a flag that reserves the trigger for the debugger, the action taken when it fires, and a hit flag. The info register lists the trigger kinds that the selected slot can take.

Every data-register write is legalized before it is stored. Unsupported action codes, an enter-debug action on a trigger that is not reserved for the debugger, and debugger-only bits written from outside Debug Mode are all turned into legal values. Each trigger's stored configuration is driven out so that the match logic can use it. That logic reports matches back on a per-trigger hit input. The register port is a plain single-cycle port with no back-pressure: an access is taken in the cycle its enable is high, read data is combinational in that same cycle, and writes take effect at the next clock edge.

Top module: `trig_csr_bank`

## Requirements
- R1: After reset the select register reads 0, and every trigger has action 0, debugger-only flag 0 and hit 0. The data register then reads 0x2000_0000.
- R2: The select register (address 0x7A0) keeps only the low log2(NUM_TRIG) bits of a write. With 4 triggers, writing 7 reads back 3 and writing 5 reads back 1.
- R3: For an existing trigger, the data register (address 0x7A1) reads kind 2 (address match) in bits 31:28, whatever was written there. The info register (address 0x7A4) reads the supported-kind mask 0x4.
- R4: When the select index has no trigger behind it, the info register reads 1 and the data register reads 0. A data-register write at that index changes no trigger.
- R5: A data-register write changes only the selected trigger.
- R6: An action code (bits 15:12) other than 0 or 1 is stored as 0.
- R7: Action 1 (enter Debug Mode) is kept only if the debugger-only flag (bit 27) resulting from the same write is 1. Otherwise the action is stored as 0.
- R8: Bit 27 is written only while the debug_mode input is high. A write made outside Debug Mode stores 0 there.
- R9: While a trigger's bit 27 is 1, writes to that trigger made outside Debug Mode are ignored.
- R10: A pulse on match_hit[i] sets trigger i's hit flag (data bit 20 and cfg_hit[i]). A write of 0 to bit 20 clears it, and a match in the same cycle as such a write wins.
- R11: With bank_present low, an access to 0x7A0, 0x7A1 or 0x7A4 raises csr_illegal, reads 0 and changes nothing. csr_illegal stays low when the bank is present or when the address is outside the bank.
- R12: Writes to the info register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_present | input | 1 | High when the trigger bank is implemented |
| debug_mode | input | 1 | High while the hart is in Debug Mode |
| csr_en | input | 1 | Register access in this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational |
| csr_illegal | output | 1 | Access to the bank while it is absent |
| match_hit | input | NUM_TRIG | Per-trigger match pulse from the match logic |
| cfg_action | output | 4*NUM_TRIG | Stored action, 4 bits per trigger |
| cfg_dmode | output | NUM_TRIG | Stored debugger-only flag per trigger |
| cfg_hit | output | NUM_TRIG | Stored hit flag per trigger |

## Verification
The assertions assume that every input is at a known level once reset is released. They also assume that a write is a single cycle with csr_en and csr_we high together, so that a select write is visible in the cycle that follows. The bench changes inputs only on falling clock edges and holds each access for exactly one cycle. It pulses match_hit for one cycle. It changes bank_present and debug_mode only while no access is in progress, so every property sees clean one-cycle events.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;
  localparam int XLEN = 32;

  localparam logic [11:0] ADDR_SELECT = 12'h7A0;
  localparam logic [11:0] ADDR_DATA1  = 12'h7A1;
  localparam logic [11:0] ADDR_INFO   = 12'h7A4;

  localparam int KIND_LSB   = 28;
  localparam int DMODE_BIT  = 27;
  localparam int HIT_BIT    = 20;
  localparam int ACTION_LSB = 12;

  localparam logic [3:0] KIND_ADDR_MATCH = 4'd2;
  localparam logic [3:0] ACT_BREAK       = 4'd0;
  localparam logic [3:0] ACT_DEBUG       = 4'd1;

  localparam logic [XLEN-1:0] INFO_SUPPORTED = XLEN'(1) << KIND_ADDR_MATCH;
  localparam logic [XLEN-1:0] INFO_MISSING   = XLEN'(1);

  typedef struct packed {
    logic       dmode;
    logic       hit;
    logic [3:0] action;
  } trig_cfg_t;

  function automatic logic [3:0] legal_action(input logic [3:0] req, input logic dmode);
    return (req == ACT_DEBUG && dmode) ? ACT_DEBUG : ACT_BREAK;
  endfunction

  function automatic logic [XLEN-1:0] data1_image(input trig_cfg_t c);
    logic [XLEN-1:0] v;
    v = '0;
    v[KIND_LSB +: 4]   = KIND_ADDR_MATCH;
    v[DMODE_BIT]       = c.dmode;
    v[HIT_BIT]         = c.hit;
    v[ACTION_LSB +: 4] = c.action;
    return v;
  endfunction
endpackage

// File: rtl/trig_csr_decode.sv
`timescale 1ns/1ps
module trig_csr_decode
  import trig_pkg::*;
(
  input  logic        csr_en,
  input  logic [11:0] csr_addr,
  input  logic        bank_present,
  output logic        sel_sel,
  output logic        sel_data1,
  output logic        sel_info,
  output logic        illegal
);
  logic in_bank;

  always_comb begin
    in_bank   = (csr_addr == ADDR_SELECT) || (csr_addr == ADDR_DATA1) ||
                (csr_addr == ADDR_INFO);
    sel_sel   = csr_en && bank_present && (csr_addr == ADDR_SELECT);
    sel_data1 = csr_en && bank_present && (csr_addr == ADDR_DATA1);
    sel_info  = csr_en && bank_present && (csr_addr == ADDR_INFO);
    illegal   = csr_en && !bank_present && in_bank;
  end
endmodule

// File: rtl/trig_slot.sv
`timescale 1ns/1ps
module trig_slot
  import trig_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            dbg_i,
  input  logic            hit_set_i,
  output trig_cfg_t       cfg_o
);
  trig_cfg_t cfg_q;
  logic      accept;
  logic      new_dmode;
  logic      unused_ok;

  assign unused_ok = ^wdata_i;
  assign accept    = wr_en_i && (!cfg_q.dmode || dbg_i);
  assign new_dmode = dbg_i ? wdata_i[DMODE_BIT] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (accept) begin
      cfg_q.dmode  <= new_dmode;
      cfg_q.action <= legal_action(wdata_i[ACTION_LSB +: 4], new_dmode);
      cfg_q.hit    <= wdata_i[HIT_BIT] | hit_set_i;
    end else if (hit_set_i) begin
      cfg_q.hit <= 1'b1;
    end
  end

  assign cfg_o = cfg_q;

  a_r6_action_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.action == ACT_BREAK || cfg_q.action == ACT_DEBUG);

  a_r7_debug_needs_dmode: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.action == ACT_DEBUG |-> cfg_q.dmode);

  a_r9_locked_outside_debug: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.dmode && !dbg_i) |=> ($stable(cfg_q.action) && $stable(cfg_q.dmode)));

  a_r5_untouched_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(cfg_q.action) && $stable(cfg_q.dmode)));

  a_r10_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit_set_i |=> cfg_q.hit);
endmodule

// File: rtl/trig_csr_bank.sv
`timescale 1ns/1ps
module trig_csr_bank
  import trig_pkg::*;
#(
  parameter int NUM_TRIG = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bank_present,
  input  logic                  debug_mode,
  input  logic                  csr_en,
  input  logic                  csr_we,
  input  logic [11:0]           csr_addr,
  input  logic [XLEN-1:0]       csr_wdata,
  output logic [XLEN-1:0]       csr_rdata,
  output logic                  csr_illegal,
  input  logic [NUM_TRIG-1:0]   match_hit,
  output logic [4*NUM_TRIG-1:0] cfg_action,
  output logic [NUM_TRIG-1:0]   cfg_dmode,
  output logic [NUM_TRIG-1:0]   cfg_hit
);
  localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam int SLOTS = 1 << SEL_W;
  localparam logic [SEL_W:0] COUNT = (SEL_W + 1)'(NUM_TRIG);

  logic             dec_sel, dec_data1, dec_info;
  logic [SEL_W-1:0] sel_q;
  logic             sel_exists;
  logic [XLEN-1:0]  img [SLOTS];

  trig_csr_decode u_decode (
    .csr_en       (csr_en),
    .csr_addr     (csr_addr),
    .bank_present (bank_present),
    .sel_sel      (dec_sel),
    .sel_data1    (dec_data1),
    .sel_info     (dec_info),
    .illegal      (csr_illegal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (dec_sel && csr_we) sel_q <= csr_wdata[SEL_W-1:0];
  end

  assign sel_exists = ({1'b0, sel_q} < COUNT);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_TRIG) begin : g_real
      trig_cfg_t cfg;
      trig_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (dec_data1 && csr_we && (sel_q == SEL_W'(g))),
        .wdata_i   (csr_wdata),
        .dbg_i     (debug_mode),
        .hit_set_i (match_hit[g]),
        .cfg_o     (cfg)
      );
      assign img[g]            = data1_image(cfg);
      assign cfg_action[4*g +: 4] = cfg.action;
      assign cfg_dmode[g]      = cfg.dmode;
      assign cfg_hit[g]        = cfg.hit;
    end else begin : g_empty
      assign img[g] = '0;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (dec_sel)
      csr_rdata = XLEN'(sel_q);
    else if (dec_data1)
      csr_rdata = sel_exists ? img[sel_q] : '0;
    else if (dec_info)
      csr_rdata = sel_exists ? INFO_SUPPORTED : INFO_MISSING;
  end

  a_r11_absent_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && !bank_present &&
     (csr_addr == ADDR_SELECT || csr_addr == ADDR_DATA1 || csr_addr == ADDR_INFO))
    |-> (csr_illegal && csr_rdata == '0));

  a_r2_select_truncates: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_we && bank_present && csr_addr == ADDR_SELECT)
    |=> sel_q == $past(csr_wdata[SEL_W-1:0]));

  a_r4_missing_info: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && bank_present && csr_addr == ADDR_INFO && !sel_exists)
    |-> csr_rdata == INFO_MISSING);
endmodule

// File: tb/trig_csr_bank_tb.sv
`timescale 1ns/1ps
module trig_csr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_present = 1'b1;
  logic        debug_mode = 1'b0;
  logic        csr_en = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] rdata4, rdata3;
  logic        ill4, ill3;
  logic [3:0]  hit4 = '0;
  logic [2:0]  hit3 = '0;
  logic [15:0] act4;
  logic [11:0] act3;
  logic [3:0]  dm4, ch4;
  logic [2:0]  dm3, ch3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trig_csr_bank #(.NUM_TRIG(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bank_present(bank_present), .debug_mode(debug_mode),
    .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(rdata4), .csr_illegal(ill4), .match_hit(hit4),
    .cfg_action(act4), .cfg_dmode(dm4), .cfg_hit(ch4));

  trig_csr_bank #(.NUM_TRIG(3)) u_dut3 (
    .clk(clk), .rst_n(rst_n), .bank_present(bank_present), .debug_mode(debug_mode),
    .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(rdata3), .csr_illegal(ill3), .match_hit(hit3),
    .cfg_action(act3), .cfg_dmode(dm3), .cfg_hit(ch3));

  localparam logic [11:0] A_SEL = 12'h7A0, A_D1 = 12'h7A1, A_INFO = 12'h7A4;

  function automatic logic [31:0] d1(input logic dm, input logic h, input logic [3:0] a);
    return 32'h2000_0000 | (32'(dm) << 27) | (32'(h) << 20) | (32'(a) << 12);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic il);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b0; csr_addr = a;
    #2;
    d = rdata4; il = ill4;
    @(negedge clk);
    csr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic il;
    rd(A_SEL, d, il);  check("R1 select", d, 0);
    rd(A_D1, d, il);   check("R1 data", d, d1(0, 0, 0));
    check("R1 cfg", {16'h0, act4}, 0);
    check("R1 flags", {24'h0, dm4, ch4}, 0);
  endtask

  task automatic t_select();
    logic [31:0] d; logic il;
    wr(A_SEL, 32'd7); rd(A_SEL, d, il); check("R2 sel 7", d, 3);
    wr(A_SEL, 32'd5); rd(A_SEL, d, il); check("R2 sel 5", d, 1);
  endtask

  task automatic t_info();
    logic [31:0] d; logic il;
    rd(A_INFO, d, il); check("R3 info", d, 32'h4);
    wr(A_D1, 32'hF000_0000); rd(A_D1, d, il); check("R3 kind", d, d1(0, 0, 0));
    wr(A_INFO, 32'hFFFF_FFFF); rd(A_INFO, d, il); check("R12 info write", d, 32'h4);
  endtask

  task automatic t_actions();
    logic [31:0] d; logic il;
    wr(A_SEL, 32'd1);
    wr(A_D1, 32'h0000_5000); rd(A_D1, d, il); check("R6 action 5", d, d1(0, 0, 0));
    wr(A_D1, 32'h0000_F000); rd(A_D1, d, il); check("R6 action 15", d, d1(0, 0, 0));
    wr(A_D1, 32'h0000_1000); rd(A_D1, d, il); check("R7 debug w/o flag", d, d1(0, 0, 0));
    wr(A_D1, 32'h0800_1000); rd(A_D1, d, il); check("R8 flag outside debug", d, d1(0, 0, 0));
    debug_mode = 1'b1;
    wr(A_D1, 32'h0800_1000); rd(A_D1, d, il); check("R7 debug with flag", d, d1(1, 0, 1));
    check("R5 only selected", {16'h0, act4}, 32'h0010);
    check("R5 flags", {28'h0, dm4}, 32'h2);
    debug_mode = 1'b0;
    wr(A_D1, 32'h0000_0000); rd(A_D1, d, il); check("R9 locked", d, d1(1, 0, 1));
    debug_mode = 1'b1;
    wr(A_D1, 32'h0000_0000); rd(A_D1, d, il); check("R9 debug write", d, d1(0, 0, 0));
    debug_mode = 1'b0;
  endtask

  task automatic t_hit();
    logic [31:0] d; logic il;
    wr(A_SEL, 32'd2);
    @(negedge clk); hit4 = 4'b0100; @(negedge clk); hit4 = '0;
    check("R10 cfg_hit", {28'h0, ch4}, 32'h4);
    rd(A_D1, d, il); check("R10 hit read", d, d1(0, 1, 0));
    wr(A_D1, 32'h0); rd(A_D1, d, il); check("R10 clear", d, d1(0, 0, 0));
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = A_D1; csr_wdata = 32'h0; hit4 = 4'b0100;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0; hit4 = '0;
    rd(A_D1, d, il); check("R10 set wins", d, d1(0, 1, 0));
  endtask

  task automatic t_missing();
    logic [11:0] a_before; logic [2:0] dm_before;
    wr(A_SEL, 32'd3);
    @(negedge clk); csr_en = 1'b1; csr_we = 1'b0; csr_addr = A_INFO; #2;
    check("R4 info missing", rdata3, 32'h1);
    csr_addr = A_D1; #2;
    check("R4 data missing", rdata3, 32'h0);
    @(negedge clk); csr_en = 1'b0;
    a_before = act3; dm_before = dm3;
    debug_mode = 1'b1;
    wr(A_D1, 32'h0800_1000);
    debug_mode = 1'b0;
    check("R4 write ignored", {20'h0, act3}, {20'h0, a_before});
    check("R4 flag untouched", {29'h0, dm3}, {29'h0, dm_before});
  endtask

  task automatic t_absent();
    logic [31:0] d; logic il;
    wr(A_SEL, 32'd1);
    bank_present = 1'b0;
    rd(A_SEL, d, il);  check("R11 sel flag", {31'h0, il}, 1); check("R11 sel data", d, 0);
    rd(A_D1, d, il);   check("R11 data flag", {31'h0, il}, 1);
    rd(A_INFO, d, il); check("R11 info flag", {31'h0, il}, 1);
    wr(A_SEL, 32'd2);
    bank_present = 1'b1;
    rd(A_SEL, d, il);  check("R11 write dropped", d, 1); check("R11 present flag", {31'h0, il}, 0);
    rd(12'h300, d, il); check("R11 outside bank", {31'h0, il}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_info();
    t_actions();
    t_hit();
    t_missing();
    t_absent();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule